// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block runs the opcode fetch machine cycle of a small 8-bit processor, one T state per clock. Each cycle has three phases. In the first, the program counter is placed on the address bus. In the second, the read strobe rises and memory is addressed. In the third, the byte on the data input is captured into the instruction register, and the program counter advances by one. Fetch cycles follow one another without a gap. Execution is handled elsewhere, so this block only delivers bytes and addresses.

A low ready input stretches the cycle with wait states. Ready is sampled at the end of the second T state and at the end of every wait state. Each low sample adds one clock, during which the read strobe and the address are held.

At the boundary between machine cycles, a hold request parks the sequencer and raises a hold acknowledge. At the same boundary, a halt request stops the sequencer for good and drops the bus output enable so the buses float. Halt gives no acknowledge, and only reset leaves it.

Top module: `opfetch_seq`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, the instruction register to 0, the read strobe low, hold acknowledge low and bus enable high. The reset leaves halt and hold, and the first clock after reset is the first T state of a fetch.
- R2: With ready high, a fetch lasts exactly three clocks. The read strobe is low in the first clock and high in the second and third, and the address equals the program counter throughout.
- R3: Ready is sampled at the end of the second T state and at the end of each wait state. Each low sample adds one clock, with the read strobe high and the address unchanged.
- R4: The ready level during the first and third T states has no effect on the length of the cycle.
- R5: The instruction register takes the data input sampled at the end of the third T state, and it keeps its value at all other times.
- R6: The program counter, and with it the address, increases by exactly one at the end of each completed fetch and at no other time.
- R7: A hold request is granted only when a fetch completes, never in the middle of a fetch. On the following clock, hold acknowledge is high, the read strobe is low, the address is held and the bus enable stays high.
- R8: When hold is seen low during the hold state, hold acknowledge falls on that same clock edge, and a new fetch starts at its first T state.
- R9: A halt request seen when a fetch completes drives the bus enable low and the read strobe low, and gives no hold acknowledge. The address and the instruction register stay frozen. The halt state ignores hold, ready and a withdrawn halt request until reset.
- R10: If hold and halt are both requested when a fetch completes, hold is served first. Halt is then entered directly when hold is released, provided halt is still requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 1 | Memory ready; low inserts wait states |
| hold_i | input | 1 | Request to park the bus |
| halt_i | input | 1 | Request to stop and float the buses |
| data_i | input | DATA_W (8) | Data bus input from memory |
| addr_o | output | ADDR_W (16) | Address bus, equal to the program counter |
| bus_oe_o | output | 1 | Bus output enable; low means the buses float |
| rd_o | output | 1 | Read strobe, active high |
| hold_ack_o | output | 1 | Hold acknowledge |
| ir_o | output | DATA_W (8) | Instruction register |

## Verification
The fetch is run with ready held high, with one and with three wait states, and with ready pulled low only in the first and third T states. These runs separate a correct ready sampling point from a strobe or wait count that is off by one clock. The data the memory model returns depends on the address, so a capture from the wrong cycle or a wrong increment shows up as a value mismatch. Hold is raised in the first T state to show that it is deferred to the cycle boundary. Hold and halt are then raised together to show their order of service, and halt is followed by hold, ready and halt changes to show that the halt state is final.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [2:0] {
    TS_T1   = 3'd0,
    TS_T2   = 3'd1,
    TS_TW   = 3'd2,
    TS_T3   = 3'd3,
    TS_HOLD = 3'd4,
    TS_HALT = 3'd5
  } tstate_e;

  function automatic logic strobe_phase(input tstate_e s);
    return (s == TS_T2) || (s == TS_TW) || (s == TS_T3);
  endfunction

endpackage

// File: rtl/ofs_timing.sv
module ofs_timing
  import ofs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ready_i,
  input  logic    hold_i,
  input  logic    halt_i,
  output tstate_e state_o,
  output logic    rd_o,
  output logic    oe_o,
  output logic    ack_o,
  output logic    cyc_end_o
);

  tstate_e st_q, st_n;
  logic    rd_q, oe_q, ack_q;

  // after a completed fetch or a released hold: hold beats halt
  function automatic tstate_e boundary_pick(input logic hold, input logic halt);
    if (hold)      return TS_HOLD;
    else if (halt) return TS_HALT;
    else           return TS_T1;
  endfunction

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      TS_T1:         st_n = TS_T2;
      TS_T2, TS_TW:  st_n = ready_i ? TS_T3 : TS_TW;
      TS_T3:         st_n = boundary_pick(hold_i, halt_i);
      TS_HOLD:       st_n = boundary_pick(hold_i, halt_i);
      TS_HALT:       st_n = TS_HALT;
      default:       st_n = TS_T1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TS_T1;
      rd_q  <= 1'b0;
      oe_q  <= 1'b1;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rd_q  <= strobe_phase(st_n);
      oe_q  <= (st_n != TS_HALT);
      ack_q <= (st_n == TS_HOLD);
    end
  end

  assign state_o   = st_q;
  assign rd_o      = rd_q;
  assign oe_o      = oe_q;
  assign ack_o     = ack_q;
  assign cyc_end_o = (st_q == TS_T3);

endmodule

// File: rtl/ofs_pc.sv
module ofs_pc #(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= RESET_PC;
    else if (inc_i) pc_q <= pc_q + STEP;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/ofs_ir.sv
module ofs_ir #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] ir_o
);

  logic [DATA_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst)         ir_q <= '0;
    else if (load_i) ir_q <= data_i;
  end

  assign ir_o = ir_q;

endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
  import ofs_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic              halt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bus_oe_o,
  output logic              rd_o,
  output logic              hold_ack_o,
  output logic [DATA_W-1:0] ir_o
);

  tstate_e state;
  logic    cyc_end;

  ofs_timing u_timing (
    .clk       (clk),
    .rst       (rst),
    .ready_i   (ready_i),
    .hold_i    (hold_i),
    .halt_i    (halt_i),
    .state_o   (state),
    .rd_o      (rd_o),
    .oe_o      (bus_oe_o),
    .ack_o     (hold_ack_o),
    .cyc_end_o (cyc_end)
  );

  ofs_pc #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk   (clk),
    .rst   (rst),
    .inc_i (cyc_end),
    .pc_o  (addr_o)
  );

  ofs_ir #(.DATA_W(DATA_W)) u_ir (
    .clk    (clk),
    .rst    (rst),
    .load_i (cyc_end),
    .data_i (data_i),
    .ir_o   (ir_o)
  );

endmodule

// File: rtl/ofs_checker.sv
module ofs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              bus_oe_o,
  input logic              rd_o,
  input logic              hold_ack_o,
  input logic [DATA_W-1:0] ir_o
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (addr_o == '0) && !rd_o && !hold_ack_o && bus_oe_o); // R1

  AST_STROBE_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (rd_o && $past(rd_o)) |-> $stable(addr_o)); // R3

  AST_PC_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (addr_o != $past(addr_o))) |-> (addr_o == $past(addr_o) + ADDR_W'(1))); // R6

  AST_ACK_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_o) |-> $past(hold_i)); // R7

  AST_ACK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    hold_ack_o |-> (!rd_o && bus_oe_o)); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_o |-> (!rd_o && !hold_ack_o)); // R9

  AST_HALT_FINAL: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_o |=> (!bus_oe_o && $stable(addr_o) && $stable(ir_o))); // R9

endmodule

bind opfetch_seq ofs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold_i     (hold_i),
  .addr_o     (addr_o),
  .bus_oe_o   (bus_oe_o),
  .rd_o       (rd_o),
  .hold_ack_o (hold_ack_o),
  .ir_o       (ir_o)
);

// File: tb/tb_opfetch_seq.sv
module tb_opfetch_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ready_i = 1'b1;
  logic        hold_i = 1'b0;
  logic        halt_i = 1'b0;
  logic [7:0]  data_i;
  logic [15:0] addr_o;
  logic        bus_oe_o, rd_o, hold_ack_o;
  logic [7:0]  ir_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_pc;
  logic [7:0]  exp_ir;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) + 8'h13 + a[15:8];
  endfunction

  assign data_i = mem_byte(addr_o);

  opfetch_seq dut (
    .clk(clk), .rst(rst), .ready_i(ready_i), .hold_i(hold_i), .halt_i(halt_i),
    .data_i(data_i), .addr_o(addr_o), .bus_oe_o(bus_oe_o), .rd_o(rd_o),
    .hold_ack_o(hold_ack_o), .ir_o(ir_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    step();
    step();
    chk(addr_o == 16'h0, "R1 pc", 32'(addr_o), 0);
    chk(ir_o == 8'h0, "R1 ir", 32'(ir_o), 0);
    chk(!rd_o && !hold_ack_o, "R1 rd/ack", {rd_o, hold_ack_o}, 0);
    chk(bus_oe_o, "R1 bus enable", 32'(bus_oe_o), 1);
    rst = 1'b0;
    exp_pc = 16'h0;
    exp_ir = 8'h0;
  endtask

  // starts and ends at the negedge inside T1
  task automatic fetch(input int w, input bit ready_noise);
    chk(addr_o == exp_pc, "R2 T1 address", 32'(addr_o), 32'(exp_pc));
    chk(!rd_o, "R2 T1 strobe low", 32'(rd_o), 0);
    if (ready_noise) ready_i = 1'b0;       // R4: low in T1 is ignored
    step();
    chk(rd_o, "R2 T2 strobe", 32'(rd_o), 1);
    chk(!hold_ack_o, "R7 no grant in T2", 32'(hold_ack_o), 0);
    ready_i = (w == 0);
    for (int i = 0; i < w; i++) begin
      step();
      chk(rd_o && addr_o == exp_pc, "R3 wait strobe/address", {rd_o, addr_o}, {1'b1, exp_pc});
      chk(ir_o == exp_ir, "R5 ir held in wait", 32'(ir_o), 32'(exp_ir));
      if (i == w - 1) ready_i = 1'b1;
    end
    step();
    chk(rd_o && addr_o == exp_pc, "R2 T3 strobe/address", {rd_o, addr_o}, {1'b1, exp_pc});
    chk(ir_o == exp_ir, "R5 ir held in T3", 32'(ir_o), 32'(exp_ir));
    chk(!hold_ack_o, "R7 no grant in T3", 32'(hold_ack_o), 0);
    if (ready_noise) ready_i = 1'b0;       // R4: low in T3 is ignored
    step();
    exp_ir = mem_byte(exp_pc);
    exp_pc = exp_pc + 16'd1;
    chk(ir_o == exp_ir, "R5 ir loaded", 32'(ir_o), 32'(exp_ir));
    chk(addr_o == exp_pc, "R6 pc advanced", 32'(addr_o), 32'(exp_pc));
    chk(!rd_o, "R2 strobe drops after T3", 32'(rd_o), 0);
    ready_i = 1'b1;
  endtask

  task automatic t_plain();
    for (int k = 0; k < 4; k++) fetch(0, 1'b0);
  endtask

  task automatic t_waits();
    fetch(1, 1'b0);
    fetch(3, 1'b0);
  endtask

  task automatic t_ready_noise();
    fetch(0, 1'b1);
    fetch(2, 1'b1);
  endtask

  task automatic t_hold();
    hold_i = 1'b1;
    fetch(0, 1'b0);
    chk(hold_ack_o && bus_oe_o, "R7 hold granted", {hold_ack_o, bus_oe_o}, 3);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(hold_ack_o && !rd_o, "R7 hold kept", {hold_ack_o, rd_o}, 2);
      chk(addr_o == exp_pc && ir_o == exp_ir, "R7 pc/ir held", 32'(addr_o), 32'(exp_pc));
    end
    hold_i = 1'b0;
    step();
    chk(!hold_ack_o, "R8 ack drops", 32'(hold_ack_o), 0);
    fetch(0, 1'b0);                        // R8: new fetch starts in T1
  endtask

  task automatic t_halt();
    halt_i = 1'b1;
    fetch(1, 1'b0);
    chk(!bus_oe_o && !hold_ack_o, "R9 halted", {bus_oe_o, hold_ack_o}, 0);
    hold_i = 1'b1;
    ready_i = 1'b0;
    step();
    halt_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(!bus_oe_o && !rd_o && !hold_ack_o, "R9 stays halted", {bus_oe_o, rd_o, hold_ack_o}, 0);
      chk(addr_o == exp_pc && ir_o == exp_ir, "R9 frozen", 32'(ir_o), 32'(exp_ir));
    end
    hold_i = 1'b0;
    ready_i = 1'b1;
    t_reset();                             // R1 leaves halt
    fetch(0, 1'b0);
  endtask

  task automatic t_hold_then_halt();
    hold_i = 1'b1;
    halt_i = 1'b1;
    fetch(0, 1'b0);
    chk(hold_ack_o && bus_oe_o, "R10 hold served first", {hold_ack_o, bus_oe_o}, 3);
    step();
    chk(hold_ack_o, "R10 still in hold", 32'(hold_ack_o), 1);
    hold_i = 1'b0;
    step();
    chk(!bus_oe_o && !hold_ack_o && !rd_o, "R10 halt after hold", {bus_oe_o, hold_ack_o, rd_o}, 0);
    halt_i = 1'b0;
    step();
    chk(!bus_oe_o && addr_o == exp_pc, "R10 halt kept", 32'(bus_oe_o), 0);
    t_reset();
  endtask

  task automatic t_reset_in_hold();
    hold_i = 1'b1;
    fetch(0, 1'b0);
    chk(hold_ack_o, "R7 granted before reset", 32'(hold_ack_o), 1);
    hold_i = 1'b0;
    t_reset();
    chk(!hold_ack_o, "R1 reset leaves hold", 32'(hold_ack_o), 0);
    fetch(0, 1'b0);
  endtask

  initial begin
    exp_pc = 16'h0;
    exp_ir = 8'h0;
    t_reset();
    t_plain();
    t_waits();
    t_ready_noise();
    t_hold();
    t_halt();
    t_hold_then_halt();
    t_reset_in_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule